// File: doc/BRIEF.md
# Binary and Decimal Flag ALU

An 8-bit arithmetic and logic unit for a 6502-family core. Each cycle it takes a register operand (usually the accumulator), a memory operand, an immediate mask, an operation code and the current status byte. It returns the result byte and the new status byte. Addition and subtraction work in plain binary, or in packed BCD when the decimal flag of the incoming status byte is set. Compare, three bit-test variants, a bit test against an immediate mask, and the shift and rotate family complete the set.

The arithmetic is combinational. A single register stage captures the result and the status, so a value presented before a rising edge appears on the outputs just after that edge. Instruction decode, operand fetch and memory write-back belong to the surrounding core.

Top module: `bcd_flag_alu`

## Requirements
- R1: While reset is low, and after it, until the first capturing edge, `res_out` and `stat_out` are 0x00. Outputs reflect the inputs sampled at the previous rising edge (latency of one cycle).
- R2: Status bits are C=bit0, Z=bit1, I=bit2, D=bit3, B=bit4, T=bit5, V=bit6, N=bit7. Opcode 0 (pass) and the unused codes 12 to 15 return `reg_opnd` as the result and `stat_in` unchanged.
- R3: Every flag-writing opcode (1 to 11) clears T. For add, subtract and shifts, N is result bit 7 and Z is set when the result is zero.
- R4: Opcode 1 (add) with D=0 gives A+M+C. C is the carry out of bit 7. V is set when A and M share a sign that the result does not have.
- R5: Opcode 1 with D=1 adds packed BCD digits. The low digit is corrected by +6 (with +0x10 to the high part) when it exceeds 9. V is taken from the high part after that step. The high part is corrected by +0x60 when it exceeds 0x90. C is set on a carry beyond 8 bits.
- R6: Opcode 2 (subtract) with D=0 gives A-M-(1-C). C is set when the difference is not negative. V is set when A and M differ in sign and the result sign differs from A.
- R7: Opcode 2 with D=1 subtracts packed BCD digits, giving the decimal difference modulo 100. C is set when no borrow results, and V follows the binary rule of R6.
- R8: Opcode 3 (compare) sets C when `reg_opnd` >= M, and sets N and Z from the 8-bit value `reg_opnd`-M. It leaves V unchanged and returns `reg_opnd` as the result.
- R9: Opcodes 4 (test), 5 (test and set) and 6 (test and reset) set N from M bit 7, V from M bit 6, and Z when (M AND A) is zero. The results are M, M OR A and M AND NOT A respectively.
- R10: Opcode 7 applies the R9 flag rules with `imm_mask` in place of A, returns M, and ignores `reg_opnd`.
- R11: Opcodes 8 (shift left), 9 (shift right), 10 (rotate left) and 11 (rotate right) act on M. The bit shifted out goes to C. Shifts fill the vacated bit with 0, and rotates fill it with the old C.
- R12: No opcode alters I, D or B. Compare and the shifts leave V unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| op_sel | input | 4 | Operation code |
| reg_opnd | input | 8 | Register operand (accumulator or index) |
| mem_opnd | input | 8 | Memory operand |
| imm_mask | input | 8 | Immediate mask for the two-operand test |
| stat_in | input | 8 | Current status byte |
| res_out | output | 8 | Registered result byte |
| stat_out | output | 8 | Registered updated status byte |

## Verification
The unit keeps no state beyond its output register, so every fault shows up one cycle after the faulty operands: a bad value in the result or status register is visible on the very next sample, and it is overwritten by the next operation. The corner cases that matter are the decimal correction steps (a low digit above 9, a high part above 0x90, a borrow out of the low digit), the moment at which decimal-add overflow is taken, and flag bits that must survive untouched. Those bits are T on pass, I/D/B always, and V for compare and shifts.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW   = 8;
  localparam int OPW  = 4;
  localparam int NIB  = DW / 2;

  localparam int SB_C = 0;
  localparam int SB_Z = 1;
  localparam int SB_I = 2;
  localparam int SB_D = 3;
  localparam int SB_B = 4;
  localparam int SB_T = 5;
  localparam int SB_V = 6;
  localparam int SB_N = 7;

  typedef enum logic [OPW-1:0] {
    OP_PASS = 4'd0,
    OP_ADC  = 4'd1,
    OP_SBC  = 4'd2,
    OP_CMP  = 4'd3,
    OP_TST  = 4'd4,
    OP_TSB  = 4'd5,
    OP_TRB  = 4'd6,
    OP_TSTI = 4'd7,
    OP_ASL  = 4'd8,
    OP_LSR  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          v;
  } arith_t;

  function automatic arith_t bin_add(input logic [DW-1:0] a, input logic [DW-1:0] m,
                                     input logic ci);
    logic [DW:0] s;
    arith_t o;
    s     = {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, ci};
    o.res = s[DW-1:0];
    o.c   = s[DW];
    o.v   = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ s[DW-1]);
    return o;
  endfunction

  function automatic arith_t bin_sub(input logic [DW-1:0] a, input logic [DW-1:0] m,
                                     input logic bi);
    logic [DW:0] s;
    arith_t o;
    s     = {1'b0, a} - {1'b0, m} - {{DW{1'b0}}, bi};
    o.res = s[DW-1:0];
    o.c   = ~s[DW];
    o.v   = (a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ s[DW-1]);
    return o;
  endfunction

  // Packed-BCD add: low digit first, overflow taken between the two corrections.
  function automatic arith_t dec_add(input logic [DW-1:0] a, input logic [DW-1:0] m,
                                     input logic ci);
    logic [NIB:0]    lo;
    logic [DW+1:0]   hi;
    arith_t o;
    lo = {1'b0, a[NIB-1:0]} + {1'b0, m[NIB-1:0]} + {{NIB{1'b0}}, ci};
    hi = {2'b00, a[DW-1:NIB], {NIB{1'b0}}} + {2'b00, m[DW-1:NIB], {NIB{1'b0}}};
    if (lo > (NIB+1)'(9)) begin
      lo = lo + (NIB+1)'(6);
      hi = hi + (DW+2)'(16);
    end
    o.v = ~(a[DW-1] ^ m[DW-1]) & (a[DW-1] ^ hi[DW-1]);
    if (hi > (DW+2)'(144)) hi = hi + (DW+2)'(96);
    o.c   = |hi[DW+1:DW];
    o.res = {hi[DW-1:NIB], lo[NIB-1:0]};
    return o;
  endfunction

  // Packed-BCD subtract: borrow in from the inverted carry; V as in binary.
  function automatic arith_t dec_sub(input logic [DW-1:0] a, input logic [DW-1:0] m,
                                     input logic bi);
    arith_t        b;
    logic [DW-1:0] lo;
    logic [11:0]   hi;
    arith_t o;
    b  = bin_sub(a, m, bi);
    lo = {{NIB{1'b0}}, a[NIB-1:0]} - {{NIB{1'b0}}, m[NIB-1:0]} - {{(DW-1){1'b0}}, bi};
    hi = {4'h0, a[DW-1:NIB], {NIB{1'b0}}} - {4'h0, m[DW-1:NIB], {NIB{1'b0}}};
    if (|lo[DW-1:NIB]) lo = lo - DW'(6);
    if (lo[DW-1])      hi = hi - 12'h010;
    if (|hi[11:8])     hi = hi - 12'h060;
    o.res = {hi[DW-1:NIB], lo[NIB-1:0]};
    o.c   = b.c;
    o.v   = b.v;
    return o;
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub import alu8_pkg::*; (
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] m_in,
  input  logic          carry_in,
  input  logic          dec_en,
  input  logic          do_sub,
  output logic [DW-1:0] sum_out,
  output logic          carry_out,
  output logic          ovf_out
);
  arith_t r_add, r_sub, r_sel;

  always_comb begin
    if (dec_en) begin
      r_add = dec_add(a_in, m_in, carry_in);
      r_sub = dec_sub(a_in, m_in, ~carry_in);
    end else begin
      r_add = bin_add(a_in, m_in, carry_in);
      r_sub = bin_sub(a_in, m_in, ~carry_in);
    end
    r_sel = do_sub ? r_sub : r_add;
  end

  assign sum_out   = r_sel.res;
  assign carry_out = r_sel.c;
  assign ovf_out   = r_sel.v;
endmodule

// File: rtl/alu8_bittest.sv
module alu8_bittest import alu8_pkg::*; (
  input  logic [DW-1:0] m_in,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] imm_in,
  input  logic          use_imm,
  input  logic          wr_set,
  input  logic          wr_clr,
  output logic [DW-1:0] res_out,
  output logic          neg_out,
  output logic          ovf_out,
  output logic          zero_out
);
  logic [DW-1:0] probe;

  assign probe    = use_imm ? imm_in : acc_in;
  assign neg_out  = m_in[DW-1];
  assign ovf_out  = m_in[DW-2];
  assign zero_out = ~|(m_in & probe);

  always_comb begin
    if (wr_set)      res_out = m_in | acc_in;
    else if (wr_clr) res_out = m_in & ~acc_in;
    else             res_out = m_in;
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter import alu8_pkg::*; (
  input  logic [DW-1:0] m_in,
  input  logic          carry_in,
  input  logic          go_right,
  input  logic          rotate,
  output logic [DW-1:0] res_out,
  output logic          carry_out
);
  logic fill;

  assign fill = rotate & carry_in;

  always_comb begin
    if (go_right) begin
      res_out   = {fill, m_in[DW-1:1]};
      carry_out = m_in[0];
    end else begin
      res_out   = {m_in[DW-2:0], fill};
      carry_out = m_in[DW-1];
    end
  end
endmodule

// File: rtl/bcd_flag_alu.sv
module bcd_flag_alu import alu8_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_sel,
  input  logic [DW-1:0]  reg_opnd,
  input  logic [DW-1:0]  mem_opnd,
  input  logic [DW-1:0]  imm_mask,
  input  logic [DW-1:0]  stat_in,
  output logic [DW-1:0]  res_out,
  output logic [DW-1:0]  stat_out
);
  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // Named internal events, brought out for the checker.
  logic flag_wr;
  logic dec_mode;
  logic bit_grp;
  logic shift_grp;

  assign dec_mode  = stat_in[SB_D];
  assign bit_grp   = (op == OP_TST) || (op == OP_TSB) || (op == OP_TRB) || (op == OP_TSTI);
  assign shift_grp = (op == OP_ASL) || (op == OP_LSR) || (op == OP_ROL) || (op == OP_ROR);

  logic [DW-1:0] as_res;
  logic          as_c, as_v;
  logic [DW-1:0] bt_res;
  logic          bt_n, bt_v, bt_z;
  logic [DW-1:0] sh_res;
  logic          sh_c;
  logic [DW:0]   cmp_diff;

  alu8_addsub u_addsub (
    .a_in      (reg_opnd),
    .m_in      (mem_opnd),
    .carry_in  (stat_in[SB_C]),
    .dec_en    (dec_mode),
    .do_sub    (op == OP_SBC),
    .sum_out   (as_res),
    .carry_out (as_c),
    .ovf_out   (as_v)
  );

  alu8_bittest u_bittest (
    .m_in     (mem_opnd),
    .acc_in   (reg_opnd),
    .imm_in   (imm_mask),
    .use_imm  (op == OP_TSTI),
    .wr_set   (op == OP_TSB),
    .wr_clr   (op == OP_TRB),
    .res_out  (bt_res),
    .neg_out  (bt_n),
    .ovf_out  (bt_v),
    .zero_out (bt_z)
  );

  alu8_shifter u_shifter (
    .m_in      (mem_opnd),
    .carry_in  (stat_in[SB_C]),
    .go_right  ((op == OP_LSR) || (op == OP_ROR)),
    .rotate    ((op == OP_ROL) || (op == OP_ROR)),
    .res_out   (sh_res),
    .carry_out (sh_c)
  );

  assign cmp_diff = {1'b0, reg_opnd} - {1'b0, mem_opnd};

  logic [DW-1:0] nxt_res;
  logic [DW-1:0] nxt_stat;
  logic [DW-1:0] nz_val;

  always_comb begin
    nxt_res  = reg_opnd;
    nxt_stat = stat_in;
    nz_val   = reg_opnd;
    flag_wr  = 1'b0;
    case (op)
      OP_ADC, OP_SBC: begin
        flag_wr        = 1'b1;
        nxt_res        = as_res;
        nz_val         = as_res;
        nxt_stat[SB_C] = as_c;
        nxt_stat[SB_V] = as_v;
      end
      OP_CMP: begin
        flag_wr        = 1'b1;
        nz_val         = cmp_diff[DW-1:0];
        nxt_stat[SB_C] = ~cmp_diff[DW];
      end
      OP_TST, OP_TSB, OP_TRB, OP_TSTI: begin
        flag_wr        = 1'b1;
        nxt_res        = bt_res;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        flag_wr        = 1'b1;
        nxt_res        = sh_res;
        nz_val         = sh_res;
        nxt_stat[SB_C] = sh_c;
      end
      default: ;
    endcase
    if (flag_wr) begin
      nxt_stat[SB_T] = 1'b0;
      if (bit_grp) begin
        nxt_stat[SB_N] = bt_n;
        nxt_stat[SB_V] = bt_v;
        nxt_stat[SB_Z] = bt_z;
      end else begin
        nxt_stat[SB_N] = nz_val[DW-1];
        nxt_stat[SB_Z] = ~|nz_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out  <= '0;
      stat_out <= '0;
    end else begin
      res_out  <= nxt_res;
      stat_out <= nxt_stat;
    end
  end
endmodule

// File: rtl/bcd_flag_alu_chk.sv
module bcd_flag_alu_chk import alu8_pkg::*; (
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] op_sel,
  input logic [DW-1:0]  reg_opnd,
  input logic [DW-1:0]  mem_opnd,
  input logic [DW-1:0]  stat_in,
  input logic [DW-1:0]  res_out,
  input logic [DW-1:0]  stat_out,
  input logic           flag_wr,
  input logic           shift_grp
);
  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (res_out == '0 && stat_out == '0)); // R1

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_PASS) |-> (stat_out == $past(stat_in) && res_out == $past(reg_opnd))); // R2

  AST_T_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(flag_wr)) |-> !stat_out[SB_T]); // R3

  AST_SHIFT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(shift_grp)) |-> (stat_out[SB_N] == res_out[DW-1] && stat_out[SB_Z] == (res_out == '0))); // R3

  AST_CMP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_CMP) |-> (stat_out[SB_C] == ($past(reg_opnd) >= $past(mem_opnd)))); // R8

  AST_BIT_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) >= OP_TST && $past(op_sel) <= OP_TSTI)
      |-> (stat_out[SB_N] == $past(mem_opnd[DW-1]) && stat_out[SB_V] == $past(mem_opnd[DW-2]))); // R9

  AST_TSB_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(op_sel) == OP_TSB) |-> (res_out == ($past(mem_opnd) | $past(reg_opnd)))); // R9

  AST_KEEP_IDB: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (stat_out[SB_B:SB_I] == $past(stat_in[SB_B:SB_I]))); // R12

  AST_KEEP_V: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && ($past(shift_grp) || $past(op_sel) == OP_CMP)) |-> (stat_out[SB_V] == $past(stat_in[SB_V]))); // R12
endmodule

bind bcd_flag_alu bcd_flag_alu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_sel    (op_sel),
  .reg_opnd  (reg_opnd),
  .mem_opnd  (mem_opnd),
  .stat_in   (stat_in),
  .res_out   (res_out),
  .stat_out  (stat_out),
  .flag_wr   (flag_wr),
  .shift_grp (shift_grp)
);

// File: tb/sim_bcd_flag_alu.sv
module sim_bcd_flag_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] reg_opnd = '0, mem_opnd = '0, imm_mask = '0, stat_in = '0;
  logic [7:0] res_out, stat_out;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_flag_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .reg_opnd(reg_opnd),
    .mem_opnd(mem_opnd), .imm_mask(imm_mask), .stat_in(stat_in),
    .res_out(res_out), .stat_out(stat_out)
  );

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive on a falling edge, result is visible at the next falling edge.
  task automatic apply(input logic [3:0] op, input logic [7:0] r, input logic [7:0] m,
                       input logic [7:0] imm, input logic [7:0] st);
    op_sel = op; reg_opnd = r; mem_opnd = m; imm_mask = imm; stat_in = st;
    @(negedge clk);
  endtask

  // Expected status: T cleared, N/Z from val, C given, V given when upd_v.
  function automatic logic [7:0] exp_st(input logic [7:0] st, input logic [7:0] val,
                                        input logic c, input logic v, input bit upd_v);
    logic [7:0] e;
    e = st;
    e[5] = 1'b0;
    e[7] = val[7];
    e[1] = (val == 8'h00);
    e[0] = c;
    if (upd_v) e[6] = v;
    return e;
  endfunction

  function automatic int bcd_val(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic t_reset();
    check("R1", "res in reset", res_out, 8'h00);
    check("R1", "stat in reset", stat_out, 8'h00);
    rst_n = 1'b1;
    check("R1", "res before capture", res_out, 8'h00);
  endtask

  task automatic t_pass();
    apply(4'd0, 8'h5A, 8'h11, 8'h22, 8'hFF);
    check("R2", "pass res", res_out, 8'h5A);
    check("R2", "pass stat keeps T", stat_out, 8'hFF);
    apply(4'd14, 8'hA5, 8'h00, 8'h00, 8'h21);
    check("R2", "unused code stat", stat_out, 8'h21);
    check("R2", "unused code res", res_out, 8'hA5);
  endtask

  task automatic t_bin_add();
    logic [7:0] av [4] = '{8'h50, 8'hFF, 8'h80, 8'h12};
    logic [7:0] mv [4] = '{8'h50, 8'h01, 8'h80, 8'h34};
    logic       cv [4] = '{1'b0, 1'b0, 1'b1, 1'b1};
    for (int i = 0; i < 4; i++) begin
      int s, ss;
      logic [7:0] st, r;
      st = {7'b0010010, cv[i]};
      s  = int'(av[i]) + int'(mv[i]) + int'(cv[i]);
      ss = int'($signed(av[i])) + int'($signed(mv[i])) + int'(cv[i]);
      r  = 8'(s);
      apply(4'd1, av[i], mv[i], 8'h00, st);
      check("R4", "add res", res_out, r);
      check("R4 R3", "add stat", stat_out, exp_st(st, r, s > 255, (ss > 127) || (ss < -128), 1'b1));
    end
  endtask

  task automatic t_dec_add();
    logic [7:0] av [4] = '{8'h45, 8'h99, 8'h58, 8'h12};
    logic [7:0] mv [4] = '{8'h38, 8'h01, 8'h46, 8'h34};
    logic       cv [4] = '{1'b0, 1'b0, 1'b1, 1'b0};
    logic       vv [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
    for (int i = 0; i < 4; i++) begin
      int s;
      logic [7:0] st, r;
      st = {7'b0010100, cv[i]};
      s  = bcd_val(av[i]) + bcd_val(mv[i]) + int'(cv[i]);
      r  = to_bcd(s % 100);
      apply(4'd1, av[i], mv[i], 8'h00, st);
      check("R5", "bcd add res", res_out, r);
      check("R5", "bcd add stat", stat_out, exp_st(st, r, s >= 100, vv[i], 1'b1));
    end
  endtask

  task automatic t_bin_sub();
    logic [7:0] av [3] = '{8'h50, 8'h10, 8'h80};
    logic [7:0] mv [3] = '{8'hB0, 8'h10, 8'h01};
    logic       cv [3] = '{1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 3; i++) begin
      int s, ss;
      logic [7:0] st, r;
      st = {7'b0100000, cv[i]};
      s  = int'(av[i]) - int'(mv[i]) - int'(!cv[i]);
      ss = int'($signed(av[i])) - int'($signed(mv[i])) - int'(!cv[i]);
      r  = 8'(s);
      apply(4'd2, av[i], mv[i], 8'h00, st);
      check("R6", "sub res", res_out, r);
      check("R6", "sub stat", stat_out, exp_st(st, r, s >= 0, (ss > 127) || (ss < -128), 1'b1));
    end
  endtask

  task automatic t_dec_sub();
    logic [7:0] av [4] = '{8'h45, 8'h10, 8'h00, 8'h50};
    logic [7:0] mv [4] = '{8'h38, 8'h20, 8'h01, 8'h25};
    logic       cv [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
    for (int i = 0; i < 4; i++) begin
      int s, ss;
      logic [7:0] st, r;
      st = {7'b0001100, cv[i]};
      s  = bcd_val(av[i]) - bcd_val(mv[i]) - int'(!cv[i]);
      ss = int'($signed(av[i])) - int'($signed(mv[i])) - int'(!cv[i]);
      r  = to_bcd((s + 100) % 100);
      apply(4'd2, av[i], mv[i], 8'h00, st);
      check("R7", "bcd sub res", res_out, r);
      check("R7", "bcd sub stat", stat_out, exp_st(st, r, s >= 0, (ss > 127) || (ss < -128), 1'b1));
    end
  endtask

  task automatic t_cmp();
    logic [7:0] rv [3] = '{8'h40, 8'h10, 8'h80};
    logic [7:0] mv [3] = '{8'h40, 8'h20, 8'h01};
    for (int i = 0; i < 3; i++) begin
      logic [7:0] st;
      st = 8'h7C;
      apply(4'd3, rv[i], mv[i], 8'h00, st);
      check("R8", "cmp res", res_out, rv[i]);
      check("R8 R12", "cmp stat", stat_out, exp_st(st, 8'(rv[i] - mv[i]), rv[i] >= mv[i], 1'b0, 1'b0));
    end
  endtask

  task automatic t_bittest();
    apply(4'd4, 8'h0F, 8'hC0, 8'hFF, 8'h21);
    check("R9", "test res", res_out, 8'hC0);
    check("R9", "test stat", stat_out, 8'hC3);
    apply(4'd5, 8'h0F, 8'hC0, 8'h00, 8'h20);
    check("R9", "test-set res", res_out, 8'hCF);
    check("R9", "test-set stat", stat_out, 8'hC2);
    apply(4'd6, 8'h0F, 8'h4F, 8'h00, 8'hE2);
    check("R9", "test-reset res", res_out, 8'h40);
    check("R9", "test-reset stat", stat_out, 8'h40);
  endtask

  task automatic t_imm_test();
    apply(4'd7, 8'hFF, 8'h41, 8'h01, 8'h20);
    check("R10", "imm test res", res_out, 8'h41);
    check("R10", "imm hit stat", stat_out, 8'h40);
    apply(4'd7, 8'hFF, 8'h41, 8'h80, 8'h01);
    check("R10", "imm miss stat ignores reg", stat_out, 8'h43);
  endtask

  task automatic t_shift();
    apply(4'd8, 8'h00, 8'h81, 8'h00, 8'h60);
    check("R11", "shl res", res_out, 8'h02);
    check("R11 R12", "shl stat", stat_out, 8'h41);
    apply(4'd9, 8'h00, 8'h01, 8'h00, 8'h01);
    check("R11", "shr res", res_out, 8'h00);
    check("R11 R3", "shr stat", stat_out, 8'h03);
    apply(4'd10, 8'h00, 8'h80, 8'h00, 8'h1D);
    check("R11", "rol res", res_out, 8'h01);
    check("R11 R12", "rol stat", stat_out, 8'h1D);
    apply(4'd11, 8'h00, 8'h01, 8'h00, 8'h01);
    check("R11", "ror res", res_out, 8'h80);
    check("R11", "ror stat", stat_out, 8'h81);
    apply(4'd11, 8'h00, 8'h02, 8'h00, 8'h00);
    check("R11", "ror no carry res", res_out, 8'h01);
    check("R11", "ror no carry stat", stat_out, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    t_pass();
    t_bin_add();
    t_dec_add();
    t_bin_sub();
    t_dec_sub();
    t_cmp();
    t_bittest();
    t_imm_test();
    t_shift();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule